// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt sources and presents them to a processor on two request lines: a normal request and a fast request. Each line has its own enable register. A source asserts a line only while that line's enable bit for the source is set. Software changes an enable register only by writing a mask of ones to a set address or to a clear address. No read-modify-write is needed, so two agents can update different bits without racing.

A soft-pending latch lets the bus raise any source by itself. The raw pending word is the hardware source ORed with this latch, limited to the sources that exist. Each request output is a registered OR of its masked pending word. Because of this a request line can feed one source input of a parent controller of the same kind. The bus is a plain synchronous port with address, write strobe, write data, read strobe and a registered read data word. There is no vectoring, no priority encoding and no edge capture. The parameter `VALID_MASK` marks which source positions exist.

Top module: `dual_intc`

## Requirements
- R1: After reset both enable registers and the soft-pending latch are zero and `irq_o` and `fiq_o` are low. The reads of 0x00, 0x08, 0x10 and 0x28 return zero.
- R2: A write to 0x08 (normal line) or 0x28 (fast line) sets the enable bits where the write data has ones. All other enable bits keep their value.
- R3: A write to 0x0C (normal line) or 0x2C (fast line) clears the enable bits where the write data has ones. All other enable bits keep their value.
- R4: A write to 0x10 sets soft-pending bits where the data has ones, and a write to 0x14 clears them. A read of 0x10 or of 0x14 returns the soft-pending latch.
- R5: A read of 0x04 or of 0x24 returns the raw pending word, which is `(src_i | soft) & VALID_MASK`. It is level-sensitive: a bit follows its source and clears when the source drops.
- R6: A read of 0x00 returns the raw pending word ANDed with the normal enable. A read of 0x20 returns the raw pending word ANDed with the fast enable. The two lines are independent.
- R7: `irq_o` equals the OR of the normal masked word one clock earlier, and `fiq_o` does the same for the fast masked word.
- R8: A read of 0x08 or of 0x0C returns the normal enable register, and a read of 0x28 or of 0x2C returns the fast enable register.
- R9: Writes to 0x00, 0x04, 0x20 and 0x24 change no enable bit, no soft-pending bit and no output.
- R10: Bit positions outside `VALID_MASK` read as zero in every enable, soft, raw and masked word, and they never assert an output.
- R11: `bus_rdata` takes the addressed word at the clock edge where `bus_rd` is high. Unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| src_i | input | 32 | Level-sensitive interrupt sources |
| irq_o | output | 1 | Normal request line (registered) |
| fiq_o | output | 1 | Fast request line (registered) |

## Verification
A corrupted enable or soft-pending bit shows up at once in the next read of its set or clear address. It also shows up one clock later as a request line that is wrong for a given source pattern. A fault in the masking or in the OR tree shows up as a request line that disagrees with the masked-status read one clock after the inputs change. The bench therefore checks both the read-back word and the output level, at the cycle where each is due. For this it uses source patterns that hit shared bits, bits of only one line, and positions outside the valid set.

// File: rtl/dual_intc_pkg.sv
package dual_intc_pkg;
    localparam int unsigned ADDR_W = 6;
    localparam int unsigned NUM_PATHS = 2;

    localparam logic [ADDR_W-1:0] OFS_N_MASKED = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_N_RAW    = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_N_ENSET  = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_N_ENCLR  = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_SW_SET   = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_SW_CLR   = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_F_MASKED = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_F_RAW    = 6'h24;
    localparam logic [ADDR_W-1:0] OFS_F_ENSET  = 6'h28;
    localparam logic [ADDR_W-1:0] OFS_F_ENCLR  = 6'h2C;

    typedef enum logic {PATH_NORMAL = 1'b0, PATH_FAST = 1'b1} path_e;

    function automatic logic [ADDR_W-1:0] set_ofs(input int unsigned p);
        return (p == 0) ? OFS_N_ENSET : OFS_F_ENSET;
    endfunction

    function automatic logic [ADDR_W-1:0] clr_ofs(input int unsigned p);
        return (p == 0) ? OFS_N_ENCLR : OFS_F_ENCLR;
    endfunction
endpackage

// File: rtl/intc_setclr_reg.sv
module intc_setclr_reg #(
    parameter int unsigned W = 32,
    parameter logic [W-1:0] VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (set_stb) begin
            q <= (q | wdata) & VALID;
        end else if (clr_stb) begin
            q <= q & ~wdata;
        end
    end

    // R2: ones in the data are set, other bits keep their value
    a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> (((q & ($past(wdata) & VALID)) == ($past(wdata) & VALID)) &&
                     ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata)))));

    // R3: ones in the data are cleared, other bits keep their value
    a_r3_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && !set_stb) |=> (((q & $past(wdata)) == '0) &&
                                   ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata)))));

    // R9: without a strobe the register holds
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_stb && !clr_stb) |=> $stable(q));
endmodule

// File: rtl/intc_req_stage.sv
module intc_req_stage #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    input  logic [W-1:0] en,
    output logic [W-1:0] masked,
    output logic         req
);
    always_comb masked = raw & en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req <= 1'b0;
        else        req <= |masked;
    end

    // R7: request is the registered OR of the masked word
    a_r7_req_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (req == |($past(raw) & $past(en))));
endmodule

// File: rtl/dual_intc.sv
module dual_intc #(
    parameter int unsigned NUM_SRC = 32,
    parameter logic [NUM_SRC-1:0] VALID_MASK = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [5:0]         bus_addr,
    input  logic               bus_wr,
    input  logic [NUM_SRC-1:0] bus_wdata,
    input  logic               bus_rd,
    output logic [NUM_SRC-1:0] bus_rdata,
    input  logic [NUM_SRC-1:0] src_i,
    output logic               irq_o,
    output logic               fiq_o
);
    import dual_intc_pkg::*;

    logic [NUM_SRC-1:0] soft_q;
    logic [NUM_SRC-1:0] raw_w;
    logic [NUM_SRC-1:0] en_q   [NUM_PATHS];
    logic [NUM_SRC-1:0] mask_w [NUM_PATHS];
    logic [NUM_PATHS-1:0] req_w;
    logic [NUM_SRC-1:0] rd_mux;
    logic [NUM_SRC-1:0] rdata_q;

    intc_setclr_reg #(.W(NUM_SRC), .VALID(VALID_MASK)) u_soft (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (bus_wr && bus_addr == OFS_SW_SET),
        .clr_stb (bus_wr && bus_addr == OFS_SW_CLR),
        .wdata   (bus_wdata),
        .q       (soft_q)
    );

    always_comb raw_w = (src_i | soft_q) & VALID_MASK;

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        intc_setclr_reg #(.W(NUM_SRC), .VALID(VALID_MASK)) u_en (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_stb (bus_wr && bus_addr == set_ofs(p)),
            .clr_stb (bus_wr && bus_addr == clr_ofs(p)),
            .wdata   (bus_wdata),
            .q       (en_q[p])
        );
        intc_req_stage #(.W(NUM_SRC)) u_req (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw    (raw_w),
            .en     (en_q[p]),
            .masked (mask_w[p]),
            .req    (req_w[p])
        );
    end

    assign irq_o = req_w[PATH_NORMAL];
    assign fiq_o = req_w[PATH_FAST];

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            OFS_N_MASKED:             rd_mux = mask_w[PATH_NORMAL];
            OFS_F_MASKED:             rd_mux = mask_w[PATH_FAST];
            OFS_N_RAW, OFS_F_RAW:     rd_mux = raw_w;
            OFS_N_ENSET, OFS_N_ENCLR: rd_mux = en_q[PATH_NORMAL];
            OFS_F_ENSET, OFS_F_ENCLR: rd_mux = en_q[PATH_FAST];
            OFS_SW_SET, OFS_SW_CLR:   rd_mux = soft_q;
            default:                  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;

    // R10: no read word ever carries a bit outside the valid set
    a_r10_valid_only: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~VALID_MASK) == '0);

    // R11: read data holds when no read strobe was seen
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R6: a request line is never raised when its enable was empty
    a_r6_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q[PATH_NORMAL] == '0) |=> !irq_o);
endmodule

// File: tb/sim_dual_intc.sv
module sim_dual_intc;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [31:0] VMASK = 32'h7FFF_FFFE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] src_i = '0;
    logic        irq_o, fiq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_intc #(.NUM_SRC(32), .VALID_MASK(VMASK)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .src_i(src_i), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic t_reset;
        chk("R1 irq_o", {31'b0, irq_o}, 32'h0);
        chk("R1 fiq_o", {31'b0, fiq_o}, 32'h0);
        rd_chk("R1 masked", 6'h00, 32'h0);
        rd_chk("R1 normal enable", 6'h08, 32'h0);
        rd_chk("R1 soft", 6'h10, 32'h0);
        rd_chk("R1 fast enable", 6'h28, 32'h0);
    endtask

    task automatic t_enables;
        wr(6'h08, 32'h0000_00F0);
        rd_chk("R2 set", 6'h08, 32'h0000_00F0);
        wr(6'h08, 32'h0000_0F00);
        rd_chk("R2 set keeps others", 6'h08, 32'h0000_0FF0);
        wr(6'h0C, 32'h0000_0030);
        rd_chk("R3 clear", 6'h0C, 32'h0000_0FC0);
        rd_chk("R8 fast independent", 6'h2C, 32'h0);
        wr(6'h28, 32'hFFFF_FFFF);
        rd_chk("R10 fast enable valid only", 6'h2C, VMASK);
        wr(6'h2C, 32'h0000_FFFF);
        rd_chk("R3 fast clear", 6'h28, 32'h7FFF_0000);
        rd_chk("R8 normal unchanged", 6'h08, 32'h0000_0FC0);
    endtask

    task automatic t_raw_masked;
        @(negedge clk); src_i = 32'h0000_0010;
        rd_chk("R5 raw level", 6'h04, 32'h0000_0010);
        @(negedge clk); src_i = 32'h0;
        rd_chk("R5 raw drops", 6'h24, 32'h0);
        @(negedge clk); src_i = 32'h0001_0040;
        rd_chk("R6 normal masked", 6'h00, 32'h0000_0040);
        rd_chk("R6 fast masked", 6'h20, 32'h0001_0000);
        chk("R7 irq_o high", {31'b0, irq_o}, 32'h1);
        chk("R7 fiq_o high", {31'b0, fiq_o}, 32'h1);
        @(negedge clk); src_i = 32'h0000_0100;
        @(negedge clk);
        chk("R7 irq_o shared", {31'b0, irq_o}, 32'h1);
        chk("R7 fiq_o off", {31'b0, fiq_o}, 32'h0);
        wr(6'h08, 32'hFFFF_FFFF);
        @(negedge clk); src_i = 32'h8000_0001;
        rd_chk("R10 raw invalid bits", 6'h04, 32'h0);
        chk("R10 irq_o off", {31'b0, irq_o}, 32'h0);
        chk("R10 fiq_o off", {31'b0, fiq_o}, 32'h0);
        @(negedge clk); src_i = 32'h0;
    endtask

    task automatic t_timing;
        wr(6'h0C, 32'hFFFF_FFFF);
        wr(6'h2C, 32'hFFFF_FFFF);
        @(negedge clk); src_i = 32'h0000_0004;
        @(negedge clk);
        chk("R7 no enable", {31'b0, irq_o}, 32'h0);
        wr(6'h08, 32'h0000_0004);
        chk("R7 one cycle latency low", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        chk("R7 one cycle latency high", {31'b0, irq_o}, 32'h1);
        src_i = 32'h0;
        @(negedge clk);
        chk("R7 drops with source", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_soft;
        wr(6'h10, 32'h0000_0300);
        rd_chk("R4 soft via clear addr", 6'h14, 32'h0000_0300);
        rd_chk("R5 raw includes soft", 6'h04, 32'h0000_0300);
        wr(6'h08, 32'h0000_0200);
        @(negedge clk);
        chk("R4 soft raises irq", {31'b0, irq_o}, 32'h1);
        wr(6'h14, 32'h0000_0100);
        rd_chk("R4 soft clear one", 6'h10, 32'h0000_0200);
        wr(6'h14, 32'h0000_0200);
        @(negedge clk);
        chk("R4 irq after soft clear", {31'b0, irq_o}, 32'h0);
        wr(6'h10, 32'h8000_0001);
        rd_chk("R10 soft invalid bits", 6'h10, 32'h0);
    endtask

    task automatic t_readonly;
        wr(6'h00, 32'hFFFF_FFFF);
        wr(6'h04, 32'hFFFF_FFFF);
        wr(6'h20, 32'hFFFF_FFFF);
        wr(6'h24, 32'hFFFF_FFFF);
        rd_chk("R9 normal enable unchanged", 6'h08, 32'h0000_0204);
        rd_chk("R9 fast enable unchanged", 6'h28, 32'h0);
        rd_chk("R9 soft unchanged", 6'h10, 32'h0);
        chk("R9 irq_o low", {31'b0, irq_o}, 32'h0);
        chk("R9 fiq_o low", {31'b0, fiq_o}, 32'h0);
    endtask

    task automatic t_unmapped;
        rd_chk("R11 unmapped 0x18", 6'h18, 32'h0);
        rd_chk("R11 unmapped 0x3C", 6'h3C, 32'h0);
        rd_chk("R11 mapped after", 6'h0C, 32'h0000_0204);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enables();
        t_raw_masked();
        t_timing();
        t_soft();
        t_readonly();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule